// File: doc/BRIEF.md
# Accumulator ALU with skip conditions

This block is the data half of a small 8-bit controller core. It keeps an accumulator and a carry flag, and on each start strobe it applies one operation to them, with an optional byte operand taken from memory or from an immediate field. The operations cover binary add and subtract with and without carry, increment and decrement, the three bitwise logic functions, 9-bit rotates through carry, a nibble exchange, a BCD adjust after decimal addition, and direct control of the accumulator and carry.

A second family of operations tests a condition instead of computing a value. A test never writes the accumulator or the carry. When the condition does not hold, the block raises a one-cycle skip request, which the sequencer uses to turn the following instruction into a no-op. Results appear on the outputs one clock after the strobe. Register-file addressing, memory bit operations and program-counter control belong elsewhere.

Top module: `accum_skip_alu`

## Requirements
- R1: While reset is applied and after it is released, acc_o is 00h, carry_o is 0 and skip_o is 0. Reset is asserted asynchronously and released in step with the clock through two flops, so start_i is taken only from the third rising edge after rst_n goes high.
- R2: Opcode 0 (add) gives acc = acc + operand and sets carry to the carry-out. Opcode 1 (add with carry) gives acc = acc + operand + carry and sets carry to the carry-out.
- R3: Opcode 2 (subtract) gives acc = acc - operand. Opcode 3 (subtract with carry) gives acc = acc - operand - (1 - carry). In both cases carry afterwards is 1 when no borrow occurred, meaning acc >= operand + borrow-in.
- R4: Opcode 4 (increment) and opcode 5 (decrement) change acc by one with wrap-around modulo 256 and leave carry unchanged.
- R5: Opcodes 6, 7 and 8 store acc AND, OR and XOR operand, and leave carry unchanged. XOR with FFh yields the one's complement of acc.
- R6: Opcode 9 rotates right through carry: new acc = {carry, acc[7:1]} and new carry = acc[0]. Opcode 10 rotates left through carry: new acc = {acc[6:0], carry} and new carry = acc[7].
- R7: Opcode 11 exchanges acc[7:4] and acc[3:0] and leaves carry unchanged.
- R8: Opcode 12 (decimal correct) adds 06h when acc[3:0] > 9, and adds 60h when acc[7:4] > 9 or carry is 1. Both tests use the values present before the operation. Carry becomes 1 if it was 1, if the upper nibble was above 9, or if the sum overflowed 8 bits.
- R9: Opcode 13 clears acc and leaves carry unchanged. Opcode 14 sets carry and opcode 15 clears carry, with acc unchanged.
- R10: Opcodes 16 (equal), 17 (not equal), 18 (acc greater than operand, unsigned), 19 (carry set) and 20 (carry clear) raise skip_o exactly when the tested condition is false. They never change acc or carry.
- R11: skip_o is high only in the cycle after a start of a test whose condition failed. Cycles without start_i, and opcodes 21 to 31, change neither acc nor carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Performs op_i in this cycle |
| op_i | input | 5 | Operation code |
| operand_i | input | 8 | Memory or immediate operand |
| acc_o | output | 8 | Accumulator |
| carry_o | output | 1 | Carry flag |
| skip_o | output | 1 | Skip request for the next instruction |

## Verification
Accumulator and carry are state, so a wrong value is not lost: it carries into every later result. The vector walk therefore chains operations, and each entry depends on what the previous entries left behind. An arithmetic error in the adder or in the borrow logic shows on acc_o or carry_o one cycle after the faulty strobe, and every later check then fails too. A skip request that stays high too long or comes too early shows in the cycle straight after the test, which a directed check with an idle cycle observes.

// File: rtl/accum_skip_alu_pkg.sv
package accum_skip_alu_pkg;
  localparam int DATA_W = 8;
  localparam int OP_W   = 5;
  localparam int NIB_W  = DATA_W / 2;

  localparam logic [OP_W-1:0] OP_ADD  = 5'd0;
  localparam logic [OP_W-1:0] OP_ADC  = 5'd1;
  localparam logic [OP_W-1:0] OP_SUB  = 5'd2;
  localparam logic [OP_W-1:0] OP_SBC  = 5'd3;
  localparam logic [OP_W-1:0] OP_INC  = 5'd4;
  localparam logic [OP_W-1:0] OP_DEC  = 5'd5;
  localparam logic [OP_W-1:0] OP_AND  = 5'd6;
  localparam logic [OP_W-1:0] OP_OR   = 5'd7;
  localparam logic [OP_W-1:0] OP_XOR  = 5'd8;
  localparam logic [OP_W-1:0] OP_RRC  = 5'd9;
  localparam logic [OP_W-1:0] OP_RLC  = 5'd10;
  localparam logic [OP_W-1:0] OP_SWAP = 5'd11;
  localparam logic [OP_W-1:0] OP_DCOR = 5'd12;
  localparam logic [OP_W-1:0] OP_CLR  = 5'd13;
  localparam logic [OP_W-1:0] OP_SETC = 5'd14;
  localparam logic [OP_W-1:0] OP_CLRC = 5'd15;
  localparam logic [OP_W-1:0] OP_TEQ  = 5'd16;
  localparam logic [OP_W-1:0] OP_TNE  = 5'd17;
  localparam logic [OP_W-1:0] OP_TGT  = 5'd18;
  localparam logic [OP_W-1:0] OP_TC   = 5'd19;
  localparam logic [OP_W-1:0] OP_TNC  = 5'd20;

  typedef enum logic [1:0] {
    CLS_NONE  = 2'd0,
    CLS_ARITH = 2'd1,
    CLS_BITS  = 2'd2,
    CLS_TEST  = 2'd3
  } op_class_e;

  function automatic op_class_e classify(input logic [OP_W-1:0] op);
    if (op <= OP_DEC || op == OP_DCOR)  return CLS_ARITH;
    else if (op <= OP_CLRC)             return CLS_BITS;
    else if (op <= OP_TNC)              return CLS_TEST;
    else                                return CLS_NONE;
  endfunction
endpackage

// File: rtl/accum_skip_alu_arith.sv
module accum_skip_alu_arith
  import accum_skip_alu_pkg::*;
(
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] opnd,
  input  logic              cin,
  output logic [DATA_W-1:0] res,
  output logic              cout
);
  localparam logic [DATA_W:0] ONE      = {{DATA_W{1'b0}}, 1'b1};
  localparam logic [DATA_W:0] LO_FIX   = 9'h006;
  localparam logic [DATA_W:0] HI_FIX   = 9'h060;
  localparam logic [NIB_W-1:0] BCD_MAX = 4'd9;

  logic [DATA_W:0] acc_x, opnd_x, cin_x, bor_x;
  logic [DATA_W:0] sum, diff, dec_sum;
  logic            lo_big, hi_big;

  always_comb begin
    acc_x  = {1'b0, acc};
    opnd_x = {1'b0, opnd};
    cin_x  = {{DATA_W{1'b0}}, cin};
    bor_x  = {{DATA_W{1'b0}}, ~cin};
    lo_big = acc[NIB_W-1:0] > BCD_MAX;
    hi_big = (acc[DATA_W-1:NIB_W] > BCD_MAX) || cin;
    dec_sum = acc_x + (lo_big ? LO_FIX : '0) + (hi_big ? HI_FIX : '0);
    sum  = '0;
    diff = '0;
    res  = acc;
    cout = cin;
    case (op)
      OP_ADD: begin sum = acc_x + opnd_x;         res = sum[DATA_W-1:0]; cout = sum[DATA_W]; end
      OP_ADC: begin sum = acc_x + opnd_x + cin_x; res = sum[DATA_W-1:0]; cout = sum[DATA_W]; end
      OP_SUB: begin diff = acc_x - opnd_x;         res = diff[DATA_W-1:0]; cout = ~diff[DATA_W]; end
      OP_SBC: begin diff = acc_x - opnd_x - bor_x; res = diff[DATA_W-1:0]; cout = ~diff[DATA_W]; end
      OP_INC: begin sum = acc_x + ONE; res = sum[DATA_W-1:0]; end
      OP_DEC: begin diff = acc_x - ONE; res = diff[DATA_W-1:0]; end
      OP_DCOR: begin res = dec_sum[DATA_W-1:0]; cout = hi_big | dec_sum[DATA_W]; end
      default: ;
    endcase
  end
endmodule

// File: rtl/accum_skip_alu_bits.sv
module accum_skip_alu_bits
  import accum_skip_alu_pkg::*;
(
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] opnd,
  input  logic              cin,
  output logic [DATA_W-1:0] res,
  output logic              cout
);
  always_comb begin
    res  = acc;
    cout = cin;
    case (op)
      OP_AND:  res = acc & opnd;
      OP_OR:   res = acc | opnd;
      OP_XOR:  res = acc ^ opnd;
      OP_RRC:  begin res = {cin, acc[DATA_W-1:1]}; cout = acc[0]; end
      OP_RLC:  begin res = {acc[DATA_W-2:0], cin}; cout = acc[DATA_W-1]; end
      OP_SWAP: res = {acc[NIB_W-1:0], acc[DATA_W-1:NIB_W]};
      OP_CLR:  res = '0;
      OP_SETC: cout = 1'b1;
      OP_CLRC: cout = 1'b0;
      default: ;
    endcase
  end
endmodule

// File: rtl/accum_skip_alu_test.sv
module accum_skip_alu_test
  import accum_skip_alu_pkg::*;
(
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] opnd,
  input  logic              cin,
  output logic              skip
);
  logic holds;

  always_comb begin
    case (op)
      OP_TEQ:  holds = (acc == opnd);
      OP_TNE:  holds = (acc != opnd);
      OP_TGT:  holds = (acc > opnd);
      OP_TC:   holds = cin;
      OP_TNC:  holds = ~cin;
      default: holds = 1'b1;
    endcase
    skip = ~holds;
  end
endmodule

// File: rtl/accum_skip_alu.sv
module accum_skip_alu
  import accum_skip_alu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] operand_i,
  output logic [DATA_W-1:0] acc_o,
  output logic              carry_o,
  output logic              skip_o
);
  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  logic [DATA_W-1:0] acc_q, acc_d;
  logic              carry_q, carry_d;
  logic              skip_q, skip_d;
  logic              acc_en;
  logic [DATA_W-1:0] ar_res, bt_res;
  logic              ar_c, bt_c, tst_skip;
  op_class_e         cls;

  // reset: asserted at once, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  accum_skip_alu_arith u_arith (
    .op(op_i), .acc(acc_q), .opnd(operand_i), .cin(carry_q),
    .res(ar_res), .cout(ar_c)
  );

  accum_skip_alu_bits u_bits (
    .op(op_i), .acc(acc_q), .opnd(operand_i), .cin(carry_q),
    .res(bt_res), .cout(bt_c)
  );

  accum_skip_alu_test u_test (
    .op(op_i), .acc(acc_q), .opnd(operand_i), .cin(carry_q),
    .skip(tst_skip)
  );

  always_comb begin
    cls     = classify(op_i);
    acc_d   = acc_q;
    carry_d = carry_q;
    skip_d  = 1'b0;
    acc_en  = 1'b0;
    if (start_i) begin
      case (cls)
        CLS_ARITH: begin acc_d = ar_res; carry_d = ar_c; acc_en = 1'b1; end
        CLS_BITS:  begin acc_d = bt_res; carry_d = bt_c; acc_en = 1'b1; end
        CLS_TEST:  skip_d = tst_skip;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      acc_q   <= '0;
      carry_q <= 1'b0;
    end else if (acc_en) begin
      acc_q   <= acc_d;
      carry_q <= carry_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) skip_q <= 1'b0;
    else             skip_q <= skip_d;
  end

  assign acc_o   = acc_q;
  assign carry_o = carry_q;
  assign skip_o  = skip_q;
endmodule

// File: rtl/accum_skip_alu_chk.sv
module accum_skip_alu_chk
  import accum_skip_alu_pkg::*;
(
  input logic              clk,
  input logic              rst_ok_n,
  input logic              start_i,
  input logic [OP_W-1:0]   op_i,
  input logic [DATA_W-1:0] acc_o,
  input logic              carry_o,
  input logic              skip_o,
  input logic [DATA_W-1:0] operand_i
);
  a_r10_test_keeps_state: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (start_i && op_i >= OP_TEQ && op_i <= OP_TNC) |=> ($stable(acc_o) && $stable(carry_o)));

  a_r11_idle_holds: assert property (@(posedge clk) disable iff (!rst_ok_n)
    !start_i |=> ($stable(acc_o) && $stable(carry_o) && !skip_o));

  a_r11_skip_needs_start: assert property (@(posedge clk) disable iff (!rst_ok_n)
    skip_o |-> $past(start_i));

  a_r4_inc_wraps: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (start_i && op_i == OP_INC) |=> (acc_o == $past(acc_o) + 8'd1 && $stable(carry_o)));

  a_r9_setc: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (start_i && op_i == OP_SETC) |=> carry_o);

  a_r9_clrc: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (start_i && op_i == OP_CLRC) |=> !carry_o);

  a_r5_xor_ff_complements: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (start_i && op_i == OP_XOR && operand_i == 8'hFF) |=> (acc_o == ~$past(acc_o)));

  a_r7_swap: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (start_i && op_i == OP_SWAP) |=>
      (acc_o == {$past(acc_o[3:0]), $past(acc_o[7:4])} && $stable(carry_o)));
endmodule

bind accum_skip_alu accum_skip_alu_chk chk_i (
  .clk(clk), .rst_ok_n(rst_sync_n), .start_i(start_i), .op_i(op_i),
  .acc_o(acc_o), .carry_o(carry_o), .skip_o(skip_o), .operand_i(operand_i)
);

// File: tb/accum_skip_alu_tb_top.sv
module accum_skip_alu_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [4:0] op_i = '0;
  logic [7:0] operand_i = '0;
  logic [7:0] acc_o;
  logic       carry_o, skip_o;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  accum_skip_alu dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
    .operand_i(operand_i), .acc_o(acc_o), .carry_o(carry_o), .skip_o(skip_o)
  );

  // {op, operand, expected acc, expected carry, expected skip}, chained from reset
  localparam logic [22:0] VEC [0:32] = '{
    {5'd0,  8'h35, 8'h35, 1'b0, 1'b0},  // R2 add
    {5'd0,  8'hE0, 8'h15, 1'b1, 1'b0},  // R2 add carry out
    {5'd1,  8'h10, 8'h26, 1'b0, 1'b0},  // R2 adc with carry in
    {5'd1,  8'hFF, 8'h25, 1'b1, 1'b0},  // R2 adc overflow
    {5'd2,  8'h05, 8'h20, 1'b1, 1'b0},  // R3 sub no borrow
    {5'd2,  8'h30, 8'hF0, 1'b0, 1'b0},  // R3 sub borrow
    {5'd3,  8'h10, 8'hDF, 1'b1, 1'b0},  // R3 sbc borrow in
    {5'd3,  8'hDF, 8'h00, 1'b1, 1'b0},  // R3 sbc equal
    {5'd5,  8'h00, 8'hFF, 1'b1, 1'b0},  // R4 dec wraps
    {5'd4,  8'h00, 8'h00, 1'b1, 1'b0},  // R4 inc wraps
    {5'd7,  8'hA5, 8'hA5, 1'b1, 1'b0},  // R5 or
    {5'd6,  8'h3C, 8'h24, 1'b1, 1'b0},  // R5 and
    {5'd8,  8'hFF, 8'hDB, 1'b1, 1'b0},  // R5 xor ff
    {5'd15, 8'h00, 8'hDB, 1'b0, 1'b0},  // R9 clear carry
    {5'd9,  8'h00, 8'h6D, 1'b1, 1'b0},  // R6 rotate right
    {5'd10, 8'h00, 8'hDB, 1'b0, 1'b0},  // R6 rotate left
    {5'd11, 8'h00, 8'hBD, 1'b0, 1'b0},  // R7 swap
    {5'd13, 8'h77, 8'h00, 1'b0, 1'b0},  // R9 clear acc
    {5'd14, 8'h00, 8'h00, 1'b1, 1'b0},  // R9 set carry
    {5'd19, 8'h00, 8'h00, 1'b1, 1'b0},  // R10 carry set true
    {5'd20, 8'h00, 8'h00, 1'b1, 1'b1},  // R10 carry clear false
    {5'd15, 8'h00, 8'h00, 1'b0, 1'b0},  // R9 clear carry
    {5'd0,  8'h47, 8'h47, 1'b0, 1'b0},  // R2 load by add
    {5'd16, 8'h47, 8'h47, 1'b0, 1'b0},  // R10 equal true
    {5'd16, 8'h48, 8'h47, 1'b0, 1'b1},  // R10 equal false
    {5'd17, 8'h47, 8'h47, 1'b0, 1'b1},  // R10 not equal false
    {5'd18, 8'h46, 8'h47, 1'b0, 1'b0},  // R10 greater true
    {5'd18, 8'h47, 8'h47, 1'b0, 1'b1},  // R10 greater false on equal
    {5'd20, 8'h00, 8'h47, 1'b0, 1'b0},  // R10 carry clear true
    {5'd0,  8'h38, 8'h7F, 1'b0, 1'b0},  // R2 bcd 47+38
    {5'd12, 8'h00, 8'h85, 1'b0, 1'b0},  // R8 low fix only
    {5'd0,  8'h25, 8'hAA, 1'b0, 1'b0},  // R2 bcd 85+25
    {5'd12, 8'h00, 8'h10, 1'b1, 1'b0}   // R8 both fixes, decimal carry
  };

  task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: {acc,carry,skip} actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [4:0] op, input logic [7:0] opnd);
    @(negedge clk);
    start_i = 1'b1; op_i = op; operand_i = opnd;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", {acc_o, carry_o, skip_o}, 10'h000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after release", {acc_o, carry_o, skip_o}, 10'h000);

    for (int i = 0; i < 33; i++) begin
      issue(VEC[i][22:18], VEC[i][17:10]);
      check($sformatf("vector %0d", i), {acc_o, carry_o, skip_o}, VEC[i][9:0]);
    end

    // R11 undefined opcode has no effect (state 10h, carry 1)
    issue(5'd31, 8'hFF);
    check("R11 undefined op", {acc_o, carry_o, skip_o}, {8'h10, 1'b1, 1'b0});

    // R11 skip lasts one cycle only
    issue(5'd16, 8'h00);
    check("R11 skip raised", {acc_o, carry_o, skip_o}, {8'h10, 1'b1, 1'b1});
    @(negedge clk);
    check("R11 skip dropped when idle", {acc_o, carry_o, skip_o}, {8'h10, 1'b1, 1'b0});

    // R6 rotate right carries bit 0 out with carry in set: 10h,c1 -> 88h,c0
    issue(5'd9, 8'h00);
    check("R6 rrc with carry in", {acc_o, carry_o, skip_o}, {8'h88, 1'b0, 1'b0});

    // R1 reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset mid-run", {acc_o, carry_o, skip_o}, 10'h000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    issue(5'd4, 8'h00);
    check("R4 inc after reset", {acc_o, carry_o, skip_o}, {8'h01, 1'b0, 1'b0});

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule